// File: doc/BRIEF.md
# Machine-Cycle State Sequencer with Wait, Hold and Halt

This block is the clock-state controller of a small 8-bit processor. It steps each machine cycle through three to five clock states (T1, T2, T3, then T4 and T5 when the cycle needs them). It stretches a cycle with wait states while a slow device holds ready low. It gives the bus to an external master for direct memory access when that master raises a hold request. After a halt instruction it parks the processor until reset, hold or an enabled interrupt wakes it.

The instruction decoder supplies hints for each cycle: read or write, the number of clock states, whether this cycle ends the instruction, and whether it is the halt cycle. The hints are captured during T1. The sequencer reports its current state as a 3-bit code. It drives a sync strobe in T1, a wait flag, a hold acknowledge, address, write-data and read-data bus enables, and a one-state marker at the start of an interrupt acknowledge cycle.

Top module: `mcyc_sequencer`

## Requirements
- R1: The state code is T1=0, T2=1, T3=2, T4=3, T5=4, TW=5, THOLD=6, THALT=7. Each cycle runs T1, T2, T3 and then T4 and T5 when the state count asks for them. The count, direction, last-cycle and halt hints are sampled at the clock edge that leaves T1. A count below 3 counts as 3 and a count above 5 counts as 5. The first-cycle flag `m1` is high for the whole cycle that follows a cycle marked last.
- R2: `sync` is high exactly while the state is T1.
- R3: When ready is low at the edge leaving T2 or TW, the next state is TW. `wait_o` is high exactly in TW. When ready is high at the edge leaving TW, the next state is T3.
- R4: `addr_oe` is low whenever hold is acknowledged or the state is THALT. `data_oe` (write cycles) and `rd_en` (read cycles) are high only in T2, TW and T3, and only while hold is not acknowledged.
- R5: In a read cycle, a hold request seen with ready high at the edge leaving T2 or TW raises `hold_ack` together with T3. After the cycle's last state, the state goes to THOLD.
- R6: In a write cycle, a hold request seen that way raises `hold_ack` at the edge leaving T3. The state goes to THOLD after the cycle's last state.
- R7: The state stays in THOLD while hold is requested. At the first edge with the request low, `hold_ack` drops and the state leaves THOLD.
- R8: A cycle whose halt hint is set is followed by THALT, where the state stays until reset, hold or an accepted interrupt.
- R9: In THALT, an interrupt request moves to T1 with `m1` and `int_cycle` high only if the interrupt-enable input was high at the end of the halt cycle. Otherwise the state stays THALT. `int_cycle` is high only during that one T1.
- R10: In THALT, a hold request moves to THOLD with `hold_ack` high. Releasing hold returns to THALT, not to T1.
- R11: A synchronous reset, from any state including THALT, gives T1 with `m1` high and `hold_ack` low after the edge.
- R12: At the end of a cycle marked last and not halting, an interrupt request with interrupts enabled starts an interrupt acknowledge cycle (T1 with `m1` and `int_cycle` high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ready | input | 1 | Memory or device ready |
| hold_req | input | 1 | Bus request from an external master |
| int_req | input | 1 | Interrupt request |
| int_en | input | 1 | Interrupt-enable flag from the core |
| cyc_write | input | 1 | Hint: current cycle writes (1) or reads (0) |
| cyc_states | input | CNT_W | Hint: number of clock states in the cycle |
| cyc_last | input | 1 | Hint: cycle ends the instruction |
| cyc_halt | input | 1 | Hint: cycle belongs to the halt instruction |
| state | output | 3 | Current clock-state code |
| m1 | output | 1 | Current cycle is the first of an instruction |
| sync | output | 1 | Status strobe, high in T1 |
| wait_o | output | 1 | Wait state in progress |
| hold_ack | output | 1 | Bus granted to the external master |
| addr_oe | output | 1 | Address bus drive enable |
| data_oe | output | 1 | Write-data bus drive enable |
| rd_en | output | 1 | Read-data strobe |
| int_cycle | output | 1 | First state of an interrupt acknowledge cycle |

## Verification
The hardest situations to reach are the ones where a hold request must be seen at exactly the T2 exit of a cycle of a known direction and length. One case is the 3-state write, where the acknowledge and the move into THOLD land on the same edge. The other is hold inside halt, which must fall back to THALT. The stimulus polls the state output until it reads T1, sets the hints and raises the request at that point, then steps clock by clock. A behavioural model in the bench follows every input and is compared on every clock, while randomised traffic with occasional resets covers the mixed orderings.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;

   localparam int STATE_W = 3;

   typedef enum logic [STATE_W-1:0] {
      ST_T1    = 3'd0,
      ST_T2    = 3'd1,
      ST_T3    = 3'd2,
      ST_T4    = 3'd3,
      ST_T5    = 3'd4,
      ST_TW    = 3'd5,
      ST_THOLD = 3'd6,
      ST_THALT = 3'd7
   } mstate_e;

endpackage

// File: rtl/mcyc_hint_latch.sv
module mcyc_hint_latch #(
   parameter int CNT_W      = 3,
   parameter int MIN_STATES = 3,
   parameter int MAX_STATES = 5
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             capture,
   input  logic             cyc_write,
   input  logic [CNT_W-1:0] cyc_states,
   input  logic             cyc_last,
   input  logic             cyc_halt,
   output logic             h_write,
   output logic [CNT_W-1:0] h_n,
   output logic             h_last,
   output logic             h_halt
);

   localparam logic [CNT_W-1:0] LO = CNT_W'(MIN_STATES);
   localparam logic [CNT_W-1:0] HI = CNT_W'(MAX_STATES);

   logic [CNT_W-1:0] n_clamped;

   generate
      if (MIN_STATES == MAX_STATES) begin : g_fixed
         assign n_clamped = LO;
      end else begin : g_clamp
         assign n_clamped = (cyc_states < LO) ? LO :
                            (cyc_states > HI) ? HI : cyc_states;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         h_write <= 1'b0;
         h_n     <= LO;
         h_last  <= 1'b1;
         h_halt  <= 1'b0;
      end else if (capture) begin
         h_write <= cyc_write;
         h_n     <= n_clamped;
         h_last  <= cyc_last;
         h_halt  <= cyc_halt;
      end
   end

endmodule

// File: rtl/mcyc_hold_ctl.sv
module mcyc_hold_ctl
   import mcyc_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  mstate_e st,
   input  logic    ready,
   input  logic    hold_req,
   input  logic    h_write,
   output logic    hold_ack,
   output logic    hold_pend
);

   logic sample;
   assign sample = (st == ST_T2 || st == ST_TW) && ready && hold_req;

   always_ff @(posedge clk) begin
      if (rst) begin
         hold_ack  <= 1'b0;
         hold_pend <= 1'b0;
      end else if (st == ST_THOLD) begin
         hold_pend <= 1'b0;
         if (!hold_req) hold_ack <= 1'b0;
      end else if (sample) begin
         hold_pend <= 1'b1;
         if (!h_write) hold_ack <= 1'b1;
      end else if (st == ST_T3 && hold_pend && h_write) begin
         hold_ack <= 1'b1;
      end else if (st == ST_THALT && hold_req) begin
         hold_ack <= 1'b1;
      end
   end

   // R5
   rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
      ((st == ST_T2 || st == ST_TW) && ready && hold_req && !h_write) |=> hold_ack);

   // R7
   hold_rel_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_THOLD && !hold_req) |=> !hold_ack);

endmodule

// File: rtl/mcyc_state_fsm.sv
module mcyc_state_fsm
   import mcyc_pkg::*;
#(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ready,
   input  logic             hold_req,
   input  logic             int_req,
   input  logic             int_en,
   input  logic [CNT_W-1:0] h_n,
   input  logic             h_last,
   input  logic             h_halt,
   input  logic             hold_pend,
   output mstate_e          st,
   output logic             m1,
   output logic             int_cycle
);

   localparam logic [CNT_W-1:0] N3 = CNT_W'(3);
   localparam logic [CNT_W-1:0] N4 = CNT_W'(4);

   mstate_e st_n;
   logic    m1_n, intc_n, cyc_end;
   logic    ret_halt, ret_halt_n;
   logic    en_h, en_h_n;

   always_comb begin
      st_n       = st;
      m1_n       = m1;
      intc_n     = 1'b0;
      ret_halt_n = ret_halt;
      en_h_n     = en_h;
      cyc_end    = 1'b0;
      case (st)
         ST_T1: st_n = ST_T2;
         ST_T2, ST_TW: st_n = ready ? ST_T3 : ST_TW;
         ST_T3: if (h_n > N3) st_n = ST_T4; else cyc_end = 1'b1;
         ST_T4: if (h_n > N4) st_n = ST_T5; else cyc_end = 1'b1;
         ST_T5: cyc_end = 1'b1;
         ST_THOLD: begin
            if (!hold_req) begin
               if (ret_halt) begin
                  st_n = ST_THALT;
               end else begin
                  st_n = ST_T1;
                  m1_n = h_last;
               end
            end
         end
         ST_THALT: begin
            if (hold_req) begin
               st_n       = ST_THOLD;
               ret_halt_n = 1'b1;
            end else if (int_req && en_h) begin
               st_n   = ST_T1;
               m1_n   = 1'b1;
               intc_n = 1'b1;
            end
         end
         default: st_n = ST_T1;
      endcase
      if (cyc_end) begin
         if (h_halt) en_h_n = int_en;
         if (hold_pend) begin
            st_n       = ST_THOLD;
            ret_halt_n = h_halt;
         end else if (h_halt) begin
            st_n = ST_THALT;
         end else if (h_last && int_req && int_en) begin
            st_n   = ST_T1;
            m1_n   = 1'b1;
            intc_n = 1'b1;
         end else begin
            st_n = ST_T1;
            m1_n = h_last;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st        <= ST_T1;
         m1        <= 1'b1;
         int_cycle <= 1'b0;
         ret_halt  <= 1'b0;
         en_h      <= 1'b0;
      end else begin
         st        <= st_n;
         m1        <= m1_n;
         int_cycle <= intc_n;
         ret_halt  <= ret_halt_n;
         en_h      <= en_h_n;
      end
   end

   // R1
   t1_step_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_T1) |=> (st == ST_T2));

   // R3
   tw_exit_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_TW && ready) |=> (st == ST_T3));

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_THALT && hold_req) |=> (st == ST_THOLD));

endmodule

// File: rtl/mcyc_sequencer.sv
module mcyc_sequencer
   import mcyc_pkg::*;
#(
   parameter int CNT_W      = 3,
   parameter int MIN_STATES = 3,
   parameter int MAX_STATES = 5
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               ready,
   input  logic               hold_req,
   input  logic               int_req,
   input  logic               int_en,
   input  logic               cyc_write,
   input  logic [CNT_W-1:0]   cyc_states,
   input  logic               cyc_last,
   input  logic               cyc_halt,
   output logic [STATE_W-1:0] state,
   output logic               m1,
   output logic               sync,
   output logic               wait_o,
   output logic               hold_ack,
   output logic               addr_oe,
   output logic               data_oe,
   output logic               rd_en,
   output logic               int_cycle
);

   generate
      if (MIN_STATES < 3 || MAX_STATES > 5 || MIN_STATES > MAX_STATES) begin : g_bad_range
         $error("mcyc_sequencer: state count range must lie within 3..5");
      end
      if (MAX_STATES >= (1 << CNT_W)) begin : g_bad_width
         $error("mcyc_sequencer: CNT_W too narrow for MAX_STATES");
      end
   endgenerate

   mstate_e          st;
   logic             h_write, h_last, h_halt, hold_pend;
   logic [CNT_W-1:0] h_n;
   logic             in_xfer;

   mcyc_hint_latch #(
      .CNT_W     (CNT_W),
      .MIN_STATES(MIN_STATES),
      .MAX_STATES(MAX_STATES)
   ) i_hints (
      .clk       (clk),
      .rst       (rst),
      .capture   (st == ST_T1),
      .cyc_write (cyc_write),
      .cyc_states(cyc_states),
      .cyc_last  (cyc_last),
      .cyc_halt  (cyc_halt),
      .h_write   (h_write),
      .h_n       (h_n),
      .h_last    (h_last),
      .h_halt    (h_halt)
   );

   mcyc_hold_ctl i_hold (
      .clk      (clk),
      .rst      (rst),
      .st       (st),
      .ready    (ready),
      .hold_req (hold_req),
      .h_write  (h_write),
      .hold_ack (hold_ack),
      .hold_pend(hold_pend)
   );

   mcyc_state_fsm #(
      .CNT_W(CNT_W)
   ) i_fsm (
      .clk      (clk),
      .rst      (rst),
      .ready    (ready),
      .hold_req (hold_req),
      .int_req  (int_req),
      .int_en   (int_en),
      .h_n      (h_n),
      .h_last   (h_last),
      .h_halt   (h_halt),
      .hold_pend(hold_pend),
      .st       (st),
      .m1       (m1),
      .int_cycle(int_cycle)
   );

   assign in_xfer = (st == ST_T2) || (st == ST_TW) || (st == ST_T3);
   assign state   = st;
   assign sync    = (st == ST_T1);
   assign wait_o  = (st == ST_TW);
   assign addr_oe = !hold_ack && (st != ST_THALT);
   assign data_oe = in_xfer && h_write && !hold_ack;
   assign rd_en   = in_xfer && !h_write && !hold_ack;

   // R4
   halt_bus_chk: assert property (@(posedge clk) disable iff (rst)
      (st == ST_THALT) |-> (!data_oe && !rd_en && !hold_ack));

   // R2
   sync_single_chk: assert property (@(posedge clk) disable iff (rst)
      sync |=> !sync);

endmodule

// File: tb/test_mcyc_sequencer.sv
module test_mcyc_sequencer;
   timeunit 1ns;
   timeprecision 100ps;

   logic       clk = 1'b0, rst = 1'b1, ready = 1'b1, hold_req = 1'b0;
   logic       int_req = 1'b0, int_en = 1'b0, cyc_write = 1'b0;
   logic       cyc_last = 1'b1, cyc_halt = 1'b0;
   logic [2:0] cyc_states = 3'd3;
   logic [2:0] state;
   logic       m1, sync, wait_o, hold_ack, addr_oe, data_oe, rd_en, int_cycle;

   int total = 0, bad = 0;

   // reference model state
   int ms = 0, mn = 3;
   bit mm1 = 1, mack = 0, mpend = 0, mw = 0, mlast = 1, mhalt = 0;
   bit mret = 0, meh = 0, mintc = 0, started = 0;

   always #2.5 clk = ~clk;

   mcyc_sequencer i_mcyc_sequencer (
      .clk(clk), .rst(rst), .ready(ready), .hold_req(hold_req),
      .int_req(int_req), .int_en(int_en), .cyc_write(cyc_write),
      .cyc_states(cyc_states), .cyc_last(cyc_last), .cyc_halt(cyc_halt),
      .state(state), .m1(m1), .sync(sync), .wait_o(wait_o),
      .hold_ack(hold_ack), .addr_oe(addr_oe), .data_oe(data_oe),
      .rd_en(rd_en), .int_cycle(int_cycle)
   );

   task automatic cmp(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   task model_step;
      int  nx, c;
      bit  nm1, nint, endc, nack, npend, nret, neh;
      nx = ms; nm1 = mm1; nint = 0; endc = 0;
      nack = mack; npend = mpend; nret = mret; neh = meh;
      case (ms)
         0: nx = 1;
         1, 5: nx = ready ? 2 : 5;
         2: if (mn > 3) nx = 3; else endc = 1;
         3: if (mn > 4) nx = 4; else endc = 1;
         4: endc = 1;
         6: if (!hold_req) begin
               if (mret) nx = 7;
               else begin nx = 0; nm1 = mlast; end
            end
         default: if (hold_req) begin nx = 6; nret = 1; end
                  else if (int_req && meh) begin nx = 0; nm1 = 1; nint = 1; end
      endcase
      if (endc) begin
         if (mhalt) neh = int_en;
         if (mpend) begin nx = 6; nret = mhalt; end
         else if (mhalt) nx = 7;
         else if (mlast && int_req && int_en) begin nx = 0; nm1 = 1; nint = 1; end
         else begin nx = 0; nm1 = mlast; end
      end
      if (ms == 6) begin
         npend = 0;
         if (!hold_req) nack = 0;
      end else if ((ms == 1 || ms == 5) && ready && hold_req) begin
         npend = 1;
         if (!mw) nack = 1;
      end else if (ms == 2 && mpend && mw) nack = 1;
      else if (ms == 7 && hold_req) nack = 1;
      if (ms == 0) begin
         c = int'(cyc_states);
         mw = cyc_write; mlast = cyc_last; mhalt = cyc_halt;
         mn = (c < 3) ? 3 : (c > 5) ? 5 : c;
      end
      ms = nx; mm1 = nm1; mintc = nint; mack = nack; mpend = npend;
      mret = nret; meh = neh;
   endtask

   always @(posedge clk) begin
      started = 1;
      if (rst) begin
         ms = 0; mm1 = 1; mack = 0; mpend = 0; mw = 0; mn = 3; mlast = 1;
         mhalt = 0; mret = 0; meh = 0; mintc = 0;
      end else model_step();
   end

   always @(negedge clk) begin
      if (started) begin
         bit xf;
         xf = (ms == 1 || ms == 5 || ms == 2);
         cmp("R1 state", int'(state), ms);
         cmp("R1 m1", int'(m1), int'(mm1));
         cmp("R2 sync", int'(sync), int'(ms == 0));
         cmp("R3 wait_o", int'(wait_o), int'(ms == 5));
         cmp("R5 R6 R7 hold_ack", int'(hold_ack), int'(mack));
         cmp("R4 addr_oe", int'(addr_oe), int'(!mack && ms != 7));
         cmp("R4 data_oe", int'(data_oe), int'(xf && mw && !mack));
         cmp("R4 rd_en", int'(rd_en), int'(xf && !mw && !mack));
         cmp("R9 R12 int_cycle", int'(int_cycle), int'(mintc));
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_state(input int code);
      for (int k = 0; k < 60 && int'(state) != code; k++) @(negedge clk);
      if (int'(state) != code) cmp("R1 reach", int'(state), code);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      tick(3);
      cmp("R11 reset state", int'(state), 0);
      cmp("R11 reset m1", int'(m1), 1);
      cmp("R11 reset ack", int'(hold_ack), 0);
      rst = 1'b0;
      // R1 state counts, including clamped values
      for (int s = 0; s < 8; s++) begin
         cyc_states = 3'(s);
         tick(12);
      end
      cyc_states = 3'd3;
      // R1 first-cycle flag
      wait_state(0); cyc_last = 1'b0; tick(3);
      cmp("R1 m1 cleared", int'(m1), 0);
      cyc_last = 1'b1;
      // R3 wait states
      wait_state(1); ready = 1'b0; tick(1);
      cmp("R3 enter TW", int'(state), 5);
      tick(3); ready = 1'b1; tick(1);
      cmp("R3 leave TW", int'(state), 2);
      // R5 read hold
      cyc_write = 1'b0; cyc_states = 3'd4;
      wait_state(0); hold_req = 1'b1; tick(2);
      cmp("R5 ack at T3", int'(hold_ack), 1);
      cmp("R4 rd_en off", int'(rd_en), 0);
      tick(2);
      cmp("R5 THOLD", int'(state), 6);
      tick(3); hold_req = 1'b0; tick(1);
      cmp("R7 ack dropped", int'(hold_ack), 0);
      cmp("R7 leave THOLD", int'(state), 0);
      // R6 write hold, three states
      cyc_write = 1'b1; cyc_states = 3'd3;
      wait_state(0); hold_req = 1'b1; tick(2);
      cmp("R6 no ack at T3", int'(hold_ack), 0);
      cmp("R4 data_oe T3", int'(data_oe), 1);
      tick(1);
      cmp("R6 THOLD", int'(state), 6);
      cmp("R6 ack", int'(hold_ack), 1);
      hold_req = 1'b0; tick(2);
      // R6 write hold, five states
      cyc_states = 3'd5;
      wait_state(0); hold_req = 1'b1; tick(3);
      cmp("R6 ack at T4", int'(hold_ack), 1);
      tick(5); hold_req = 1'b0; tick(3);
      cyc_write = 1'b0; cyc_states = 3'd3;
      // R8 halt without interrupt enable
      wait_state(0); cyc_halt = 1'b1; int_en = 1'b0;
      wait_state(7); cyc_halt = 1'b0;
      int_req = 1'b1; tick(5);
      cmp("R9 stays halted", int'(state), 7);
      cmp("R8 addr off", int'(addr_oe), 0);
      int_req = 1'b0;
      // R10 hold inside halt
      hold_req = 1'b1; tick(1);
      cmp("R10 THOLD", int'(state), 6);
      cmp("R10 ack", int'(hold_ack), 1);
      tick(3); hold_req = 1'b0; tick(1);
      cmp("R10 back to THALT", int'(state), 7);
      // R11 reset out of halt
      rst = 1'b1; tick(1); rst = 1'b0;
      cmp("R11 T1 after halt", int'(state), 0);
      cmp("R11 m1 after halt", int'(m1), 1);
      // R9 halt with interrupts enabled
      cyc_halt = 1'b1; int_en = 1'b1;
      wait_state(7); cyc_halt = 1'b0;
      tick(2); int_req = 1'b1; tick(1);
      cmp("R9 wake T1", int'(state), 0);
      cmp("R9 int_cycle", int'(int_cycle), 1);
      cmp("R9 m1", int'(m1), 1);
      int_req = 1'b0; tick(1);
      cmp("R9 int_cycle pulse", int'(int_cycle), 0);
      // R12 interrupt at instruction end
      wait_state(0); int_req = 1'b1; tick(3);
      cmp("R12 int cycle", int'(int_cycle), 1);
      cmp("R12 state", int'(state), 0);
      int_req = 1'b0; tick(2);
      // mixed traffic
      for (int i = 0; i < 4000; i++) begin
         ready      = ($urandom % 4) != 0;
         if ($urandom % 16 == 0) hold_req = !hold_req;
         int_req    = ($urandom % 8) == 0;
         int_en     = $urandom % 2;
         cyc_write  = $urandom % 2;
         cyc_states = 3'($urandom % 8);
         cyc_last   = $urandom % 2;
         cyc_halt   = ($urandom % 10) == 0;
         rst        = ($urandom % 300) == 0;
         tick(1);
      end
      rst = 1'b0; hold_req = 1'b0;
      tick(4);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule